// File: doc/BRIEF.md
# Power-Down Mode Controller with Oscillator Settling Timer

This block sequences the low-power modes of a small microcontroller. It owns an 8-bit system control register on a simple write/read bus. A one-cycle sleep-instruction pulse moves it out of normal operation. A register bit decides whether that pulse enters a light sleep mode or a deep software standby mode. In light sleep only the CPU clock enable drops. In standby every internal clock enable drops and the bus pins are parked.

Any interrupt ends light sleep at once. Standby ends only on an external interrupt. The block then keeps the clocks gated for a programmable number of clock states so that the oscillator can settle, and returns to normal operation after that count. A further register bit chooses how the pins are parked. They can float in high impedance. Or the address lines can hold their last value while the control strobes are forced high.

The parameter `WAIT_SHIFT` divides every settling length by 2^WAIT_SHIFT (maximum 10). The default 0 gives the lengths in states listed below. The counter is 18 - WAIT_SHIFT bits wide.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `reg_rdata` reads 0x00, `mode` is 0 (normal), both clock enables are 1, `illegal_cfg` is 0 and all three pin controls are 0.
- R2: The register layout is: bit 7 is the standby select, bits 6:4 are the settling code, bit 1 is the pin-hold select. These bits read back as last written. Bits 3, 2 and 0 always read 0, and writes to them are ignored.
- R3: In normal mode with the standby select at 0, a `sleep_req` pulse moves `mode` to 1 (sleep) on the next edge. In sleep, `cpu_clk_en` is 0 and `per_clk_en` is 1.
- R4: In sleep, `irq_any` or `irq_ext` returns `mode` to 0 on the next edge, with no settling wait.
- R5: In normal mode with the standby select at 1, a `sleep_req` pulse moves `mode` to 2 (standby), where both clock enables are 0. `irq_any` alone leaves the block in standby.
- R6: `irq_ext` in standby starts settling (`mode` 3). The clock enables stay 0 for exactly N edges counted from the wake edge, then `mode` returns to 0. `settle_done` is high for exactly one cycle, the last settling cycle. Before scaling, N is 8192 << c states for codes c = 0 to 5, and 1024 states for code 6.
- R7: Settling code 7 is illegal. It settles for 262144 states (scaled), and a write that stores it sets `illegal_cfg`. Only reset clears `illegal_cfg`.
- R8: The standby select bit stays 1 after a standby exit, until software writes 0.
- R9: In standby and settling, pin-hold select 0 drives `pins_hiz` = 1. Pin-hold select 1 drives `addr_hold` = 1 and `strobes_high` = 1 instead. In normal and sleep modes all three are 0.
- R10: Reset during settling returns `mode` to 0, re-enables both clocks and restores the register reset value at the next edge.
- R11: `sleep_req` has no effect outside normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| sleep_req | input | 1 | One-cycle sleep-instruction pulse |
| irq_any | input | 1 | Any interrupt request (wakes from sleep) |
| irq_ext | input | 1 | External interrupt request (wakes from sleep or standby) |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| mode | output | 2 | 0 normal, 1 sleep, 2 standby, 3 settling |
| settle_done | output | 1 | Pulse in the last settling cycle |
| illegal_cfg | output | 1 | Sticky flag: illegal settling code stored |
| pins_hiz | output | 1 | Address and control pins to high impedance |
| addr_hold | output | 1 | Address pins hold their last value |
| strobes_high | output | 1 | Control strobes forced high |

## Verification
A wrong sequencer state shows at `mode` and at the clock enables on the edge after the stimulus. So a missed wake, a wrong standby-or-sleep choice, or a stray exit is visible within one cycle. A wrong settling count shows only when `cpu_clk_en` comes back: the wait is one cycle long or short, or `settle_done` lands in the wrong cycle. Every settling code is therefore swept under both pin-hold settings and the exit cycle is compared exactly. A register that loses its standby bit on wake, or a flag that is not sticky, appears on the next read of `reg_rdata` or at `illegal_cfg`.

// File: rtl/pwrdn_pkg.sv
// Shared types and helpers for the power-down controller.
// Assumes scaled settling lengths stay >= 1 (shift <= 10).
package pwrdn_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_SLEEP  = 2'd1,
        PM_STBY   = 2'd2,
        PM_SETTLE = 2'd3
    } pmode_t;

    localparam int unsigned CODE_W   = 3;
    localparam int unsigned NUM_CODE = 1 << CODE_W;
    localparam int unsigned MAX_LOG  = 18;

    // Settling length in clock cycles for a code, after scaling by 2^shift.
    function automatic int unsigned settle_len(input int unsigned code, input int unsigned shift);
        int unsigned base;
        if (code == 6)
            base = 32'd1 << 10;
        else if (code == 7)
            base = 32'd1 << MAX_LOG;
        else
            base = 32'd1 << (13 + code);
        return base >> shift;
    endfunction

endpackage

// File: rtl/pdc_sysreg.sv
// System control register: standby select, settling code, pin-hold
// select and a sticky illegal-code flag. Unused bits read zero.
// Assumes one write per cycle; a write wins over nothing else.
module pdc_sysreg
    import pwrdn_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ssel,
    output logic [CODE_W-1:0] code,
    output logic              hold_sel,
    output logic              illegal,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned SSEL_BIT = 7;
    localparam int unsigned CODE_LSB = 4;
    localparam int unsigned HOLD_BIT = 1;
    localparam logic [CODE_W-1:0] BAD_CODE = '1;

    // Store the writable fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ssel     <= 1'b0;
            code     <= '0;
            hold_sel <= 1'b0;
        end else if (wr) begin
            ssel     <= wdata[SSEL_BIT];
            code     <= wdata[CODE_LSB +: CODE_W];
            hold_sel <= wdata[HOLD_BIT];
        end
    end

    // Sticky flag raised when the illegal settling code is stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            illegal <= 1'b0;
        else if (wr && wdata[CODE_LSB +: CODE_W] == BAD_CODE)
            illegal <= 1'b1;
    end

    // Assemble read data; unused positions stay zero.
    always_comb begin
        rdata                       = '0;
        rdata[SSEL_BIT]             = ssel;
        rdata[CODE_LSB +: CODE_W]   = code;
        rdata[HOLD_BIT]             = hold_sel;
    end

endmodule

// File: rtl/pdc_settle_timer.sv
// Oscillator settling counter. Latches the code at start, counts while
// run is high and pulses done in the last cycle of the selected length.
// Assumes start and run are never high together.
module pdc_settle_timer
    import pwrdn_pkg::*;
#(
    parameter int unsigned WAIT_SHIFT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              done
);
    localparam int unsigned CNT_W = MAX_LOG - WAIT_SHIFT;

    logic [CNT_W-1:0] term_tab [NUM_CODE];
    logic [CNT_W-1:0] cnt;
    logic [CODE_W-1:0] code_q;

    // Terminal count per code, computed from the length function.
    for (genvar g = 0; g < NUM_CODE; g++) begin : g_term
        assign term_tab[g] = CNT_W'(settle_len(g, WAIT_SHIFT) - 1);
    end

    // Latch the code at the wake edge so later writes do not disturb the wait.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else if (start)
            code_q <= code;
    end

    // Count settling cycles; clear on start, on completion and on reset.
    always_ff @(posedge clk) begin
        if (!rst_n || start)
            cnt <= '0;
        else if (run)
            cnt <= done ? '0 : cnt + 1'b1;
    end

    // Last-cycle pulse.
    assign done = run && (cnt == term_tab[code_q]);

endmodule

// File: rtl/pdc_seq.sv
// Mode sequencer: normal, sleep, standby and settling.
// Assumes sleep_req is a single-cycle pulse from the instruction decoder.
module pdc_seq
    import pwrdn_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sleep_req,
    input  logic   irq_any,
    input  logic   irq_ext,
    input  logic   ssel,
    input  logic   done,
    output pmode_t state,
    output logic   start
);
    pmode_t state_nx;

    // Next-state choice.
    always_comb begin
        state_nx = state;
        unique case (state)
            PM_NORMAL: if (sleep_req) state_nx = ssel ? PM_STBY : PM_SLEEP;
            PM_SLEEP:  if (irq_any || irq_ext) state_nx = PM_NORMAL;
            PM_STBY:   if (irq_ext) state_nx = PM_SETTLE;
            PM_SETTLE: if (done) state_nx = PM_NORMAL;
            default:   state_nx = PM_NORMAL;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= PM_NORMAL;
        else
            state <= state_nx;
    end

    // Wake edge from standby starts the settling timer.
    assign start = (state == PM_STBY) && irq_ext;

endmodule

// File: rtl/pwrdn_ctrl.sv
// Power-down controller top: register, sequencer, settling timer and
// output decode for clock enables and pin parking controls.
// Assumes WAIT_SHIFT <= 10 so every scaled length is at least one cycle.
module pwrdn_ctrl
    import pwrdn_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned WAIT_SHIFT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sleep_req,
    input  logic              irq_any,
    input  logic              irq_ext,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic [1:0]        mode,
    output logic              settle_done,
    output logic              illegal_cfg,
    output logic              pins_hiz,
    output logic              addr_hold,
    output logic              strobes_high
);
    logic              ssel;
    logic [CODE_W-1:0] code;
    logic              hold_sel;
    logic              start;
    logic              done;
    pmode_t            state;
    logic              parked;

    pdc_sysreg #(.DATA_W(DATA_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .ssel     (ssel),
        .code     (code),
        .hold_sel (hold_sel),
        .illegal  (illegal_cfg),
        .rdata    (reg_rdata)
    );

    pdc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .irq_any   (irq_any),
        .irq_ext   (irq_ext),
        .ssel      (ssel),
        .done      (done),
        .state     (state),
        .start     (start)
    );

    pdc_settle_timer #(.WAIT_SHIFT(WAIT_SHIFT)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .run   (state == PM_SETTLE),
        .code  (code),
        .done  (done)
    );

    // Output decode from the sequencer state and pin-hold select.
    always_comb begin
        parked       = (state == PM_STBY) || (state == PM_SETTLE);
        cpu_clk_en   = (state == PM_NORMAL);
        per_clk_en   = (state == PM_NORMAL) || (state == PM_SLEEP);
        pins_hiz     = parked && !hold_sel;
        addr_hold    = parked && hold_sel;
        strobes_high = parked && hold_sel;
        mode         = state;
        settle_done  = done;
    end

endmodule

// File: rtl/pwrdn_ctrl_chk.sv
// Port-level property checker for the power-down controller.
module pwrdn_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_rdata,
    input logic       sleep_req,
    input logic       irq_any,
    input logic       irq_ext,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic [1:0] mode,
    input logic       settle_done,
    input logic       illegal_cfg,
    input logic       pins_hiz,
    input logic       addr_hold,
    input logic       strobes_high
);
    AST_SLEEP_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'd1 |-> !cpu_clk_en && per_clk_en); // R3
    AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && (irq_any || irq_ext)) |=> mode == 2'd0); // R4
    AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !irq_ext) |=> mode == 2'd2); // R5
    AST_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        settle_done |=> mode == 2'd0 && cpu_clk_en); // R6
    AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_cfg |=> illegal_cfg); // R7
    AST_SSEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == 2'd3 && mode == 2'd0) |-> reg_rdata[7]); // R8
    AST_PIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pins_hiz && (addr_hold || strobes_high))); // R9
    AST_SLEEP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && sleep_req && !irq_ext) |=> mode == 2'd2); // R11
endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_rdata    (reg_rdata),
    .sleep_req    (sleep_req),
    .irq_any      (irq_any),
    .irq_ext      (irq_ext),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .mode         (mode),
    .settle_done  (settle_done),
    .illegal_cfg  (illegal_cfg),
    .pins_hiz     (pins_hiz),
    .addr_hold    (addr_hold),
    .strobes_high (strobes_high)
);

// File: tb/pwrdn_ctrl_test.sv
module pwrdn_ctrl_test;
    localparam int SHIFT = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sleep_req = 1'b0;
    logic       irq_any = 1'b0;
    logic       irq_ext = 1'b0;
    logic       cpu_clk_en, per_clk_en, settle_done, illegal_cfg;
    logic       pins_hiz, addr_hold, strobes_high;
    logic [1:0] mode;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pwrdn_ctrl #(.DATA_W(8), .WAIT_SHIFT(SHIFT)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sleep_req(sleep_req), .irq_any(irq_any),
        .irq_ext(irq_ext), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .mode(mode), .settle_done(settle_done), .illegal_cfg(illegal_cfg),
        .pins_hiz(pins_hiz), .addr_hold(addr_hold), .strobes_high(strobes_high)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v; tick(); reg_wr = 1'b0;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; tick(); sleep_req = 1'b0;
    endtask

    function automatic int exp_len(input int c);
        if (c == 6) return 1024 >> SHIFT;
        if (c == 7) return 262144 >> SHIFT;
        return (8192 << c) >> SHIFT;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int k, done_n, done_k;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
        check(mode == 2'd0 && cpu_clk_en && per_clk_en, "R1 mode/clocks", mode, 0);
        check(!illegal_cfg && !pins_hiz && !addr_hold && !strobes_high, "R1 flags", illegal_cfg, 0);

        // R2 field readback and unused bits
        wr_reg(8'h5A);
        check(reg_rdata == 8'h52, "R2 readback 5A", reg_rdata, 'h52);
        check(!illegal_cfg, "R7 legal code no flag", illegal_cfg, 0);
        wr_reg(8'h0D);
        check(reg_rdata == 8'h00, "R2 unused bits", reg_rdata, 0);
        wr_reg(8'hFF);
        check(reg_rdata == 8'hF2, "R2 readback FF", reg_rdata, 'hF2);
        check(illegal_cfg, "R7 flag set", illegal_cfg, 1);
        wr_reg(8'h00);
        check(illegal_cfg, "R7 flag sticky", illegal_cfg, 1);

        // R3/R4 sleep entry and both wake sources
        for (int src = 0; src < 2; src++) begin
            pulse_sleep();
            check(mode == 2'd1, "R3 sleep entry", mode, 1);
            check(!cpu_clk_en && per_clk_en, "R3 sleep clocks", {cpu_clk_en, per_clk_en}, 1);
            check(!pins_hiz && !addr_hold && !strobes_high, "R9 pins idle in sleep", pins_hiz, 0);
            pulse_sleep();
            check(mode == 2'd1, "R11 sleep_req ignored in sleep", mode, 1);
            if (src == 0) irq_any = 1'b1; else irq_ext = 1'b1;
            tick();
            irq_any = 1'b0; irq_ext = 1'b0;
            check(mode == 2'd0 && cpu_clk_en, "R4 sleep wake", mode, 0);
        end

        // R5-R9 sweep over pin-hold select and every settling code
        for (int h = 0; h < 2; h++) begin
            for (int c = 0; c < 8; c++) begin
                wr_reg({1'b1, 3'(c), 2'b00, 1'(h), 1'b0});
                pulse_sleep();
                check(mode == 2'd2 && !cpu_clk_en && !per_clk_en, "R5 standby entry", mode, 2);
                check(pins_hiz == (h == 0) && addr_hold == (h == 1) && strobes_high == (h == 1),
                      "R9 standby pins", {pins_hiz, addr_hold, strobes_high}, h ? 3 : 4);
                irq_any = 1'b1; tick(); irq_any = 1'b0;
                check(mode == 2'd2, "R5 irq_any ignored", mode, 2);
                pulse_sleep();
                check(mode == 2'd2, "R11 sleep_req ignored in standby", mode, 2);
                irq_ext = 1'b1; tick(); irq_ext = 1'b0;
                check(mode == 2'd3 && pins_hiz == (h == 0) && addr_hold == (h == 1),
                      "R9 settling pins", mode, 3);
                k = 0; done_n = 0; done_k = -1;
                while (!cpu_clk_en && k < 5000) begin
                    if (settle_done) begin done_n++; done_k = k; end
                    tick();
                    k++;
                end
                check(k == exp_len(c), c == 7 ? "R7 illegal code wait" : "R6 settle length", k, exp_len(c));
                check(done_n == 1 && done_k == exp_len(c) - 1, "R6 done pulse", done_k, exp_len(c) - 1);
                check(mode == 2'd0 && per_clk_en, "R6 back to normal", mode, 0);
                check(reg_rdata[7] == 1'b1, "R8 standby select kept", reg_rdata[7], 1);
                check(!pins_hiz && !addr_hold && !strobes_high, "R9 pins released", pins_hiz, 0);
            end
        end

        // R10 reset during settling
        wr_reg(8'h82);
        pulse_sleep();
        irq_ext = 1'b1; tick(); irq_ext = 1'b0;
        repeat (10) tick();
        check(mode == 2'd3, "R10 settling before reset", mode, 3);
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        check(mode == 2'd0 && cpu_clk_en && per_clk_en, "R10 reset exits settling", mode, 0);
        check(reg_rdata == 8'h00 && !illegal_cfg, "R10 register reset", reg_rdata, 0);
        check(!addr_hold && !strobes_high && !pins_hiz, "R10 pins after reset", addr_hold, 0);
        // after reset the standby select is 0, so sleep is entered
        pulse_sleep();
        check(mode == 2'd1, "R3 sleep after reset", mode, 1);
        irq_any = 1'b1; tick(); irq_any = 1'b0;
        check(mode == 2'd0, "R4 wake after reset", mode, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule